// File: doc/BRIEF.md
# Composed 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns their full 16-bit product within one combinational path. It has no clock and no registers. It does not build one large array. Each operand is split into a low and a high nibble, and four nibble-by-nibble sub-multipliers form four 8-bit sub-products. These four outputs together hold 32 bits, computed from the 16 operand bits.

The sub-products overlap at weights 0, 4, 4 and 8. The four lowest product bits come straight from the low-by-low sub-product. The remaining three aligned operands, each 12 bits wide, pass through one row of full adders. Each full adder takes three data bits, using its carry input as the third one. The row produces a sum word and a carry word.

A final adder joins the sum word with the carry word moved up one column. It is made of three 4-bit slices. Each slice reports a group propagate and a group generate. A single lookahead unit turns these into every slice's carry-in at once, so no carry ripples from slice to slice.

Top module: `composed_mul8`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product `a * b`, zero-extended to 16 bits.
- R2: Each of the four sub-products equals the unsigned product of one nibble of `a` and one nibble of `b`, giving the pairs (low,low), (low,high), (high,low) and (high,high), each 8 bits wide.
- R3: `product[3:0]` equals the low four bits of the (low nibble of `a`) × (low nibble of `b`) product.
- R4: In every column of the carry-save row, the sum bit is the XOR of the three input bits and the carry bit is their majority. As a result, the sum word plus twice the carry word equals the total of the three operands.
- R5: The lookahead unit gives slice 0 a carry-in of 0. It gives slice i+1 a carry equal to G_i OR (P_i AND carry into slice i), and it forms every slice carry without rippling through the slices.
- R6: When either operand is zero, `product` is zero.
- R7: With both operands at 255, `product` is 16'hFE01. Neither the top bit of the carry-save carry word nor the carry out of the last adder slice is ever set for any operand pair.
- R8: When one operand is 1, `product` equals the other operand.
- R9: Swapping `a` and `b` leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product of `a` and `b` |

## Verification
The bound checker looks at each settled evaluation. It checks four things in every evaluation: each sub-product against its nibble pair, the carry-save identity, the lookahead carry relation across slices, and the two discarded carry bits staying clear, plus the overall product against a behavioural multiply. The bench sees only the ports. It sweeps all 65,536 operand pairs and adds seeded random pairs and directed patterns. These patterns isolate single nibble products, drive long carry chains with all-ones operands, and exercise zero, one and swapped operands. Commutativity is something only the bench's paired scenarios can show, because it links two separate evaluations.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the composed multiplier.
// Assumes all widths are multiples of the slice width.
package cmul_pkg;
    // Width of one final-adder slice and of the lookahead grouping.
    localparam int unsigned CMUL_SLICE_W = 4;
    // Number of sub-products formed from two split operands.
    localparam int unsigned CMUL_NUM_PP  = 4;
endpackage

// File: rtl/nib_mult.sv
`timescale 1ns/1ps
// Module: nib_mult
// Combinational unsigned H x H multiplier that accumulates AND-gated,
// shifted copies of the multiplicand. Output is 2H bits and never
// overflows. Assumes H >= 1.
module nib_mult #(
    parameter int unsigned H = 4
) (
    input  logic [H-1:0]   x,
    input  logic [H-1:0]   y,
    output logic [2*H-1:0] p
);
    localparam int unsigned PW = 2 * H;

    // Purpose: sum the partial rows, one per set bit of y.
    always_comb begin
        p = '0;
        for (int i = 0; i < int'(H); i++) begin
            if (y[i]) begin
                p = p + (PW'(x) << i);
            end
        end
    end
endmodule

// File: rtl/csa_row.sv
`timescale 1ns/1ps
// Module: csa_row
// One row of N full adders reducing three N-bit words to a sum word and
// a carry word. The carry-in of each adder is used as the third data bit.
// Carry bit k carries weight 2^(k+1). Assumes N >= 1.
module csa_row #(
    parameter int unsigned N = 12
) (
    input  logic [N-1:0] in0,
    input  logic [N-1:0] in1,
    input  logic [N-1:0] in2,
    output logic [N-1:0] s,
    output logic [N-1:0] c
);
    genvar k;
    generate
        for (k = 0; k < int'(N); k++) begin : g_fa
            // Purpose: one full adder column (parity sum, majority carry).
            always_comb begin
                s[k] = in0[k] ^ in1[k] ^ in2[k];
                c[k] = (in0[k] & in1[k]) | (in0[k] & in2[k]) | (in1[k] & in2[k]);
            end
        end
    endgenerate
endmodule

// File: rtl/add_slice.sv
`timescale 1ns/1ps
// Module: add_slice
// SW-bit adder slice. Produces the sum for a given carry-in, plus group
// propagate and generate terms for an external lookahead unit. The
// group terms do not depend on the carry-in. Assumes SW >= 1.
module add_slice #(
    parameter int unsigned SW = 4
) (
    input  logic [SW-1:0] x,
    input  logic [SW-1:0] y,
    input  logic          cin,
    output logic [SW-1:0] s,
    output logic          gp,
    output logic          gg
);
    logic [SW-1:0] bp;
    logic [SW-1:0] bg;
    logic [SW:0]   cc;

    // Purpose: per-bit propagate and generate.
    always_comb begin
        bp = x ^ y;
        bg = x & y;
    end

    // Purpose: group propagate/generate, independent of the carry-in.
    always_comb begin
        gp = &bp;
        gg = 1'b0;
        for (int k = 0; k < int'(SW); k++) begin
            gg = bg[k] | (bp[k] & gg);
        end
    end

    // Purpose: internal carries and sum bits once the carry-in is known.
    always_comb begin
        cc[0] = cin;
        for (int k = 0; k < int'(SW); k++) begin
            cc[k+1] = bg[k] | (bp[k] & cc[k]);
        end
        s = bp ^ cc[SW-1:0];
    end
endmodule

// File: rtl/grp_lookahead.sv
`timescale 1ns/1ps
// Module: grp_lookahead
// Carry lookahead across NS slices with a carry-in of zero. Every carry
// is a flat sum of products of group terms, so none ripples through
// another. car[i] feeds slice i; car[NS] is the final carry-out.
module grp_lookahead #(
    parameter int unsigned NS = 3
) (
    input  logic [NS-1:0] gp,
    input  logic [NS-1:0] gg,
    output logic [NS:0]   car
);
    // Purpose: expand each carry as OR over j of (G_j AND P_(j+1..i-1)).
    always_comb begin
        for (int i = 0; i <= int'(NS); i++) begin
            logic acc;
            acc = 1'b0;
            for (int j = 0; j < i; j++) begin
                logic term;
                term = gg[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & gp[k];
                end
                acc = acc | term;
            end
            car[i] = acc;
        end
    end
endmodule

// File: rtl/composed_mul8.sv
`timescale 1ns/1ps
// Module: composed_mul8
// Unsigned W x W multiplier built from four (W/2)x(W/2) sub-multipliers,
// one carry-save row and a sliced lookahead adder. Purely combinational,
// so there is no clock or reset. Assumes W is even and 3*(W/2) is a
// multiple of the slice width.
module composed_mul8 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] product
);
    import cmul_pkg::*;

    localparam int unsigned H   = W / 2;           // nibble width
    localparam int unsigned PPW = 2 * H;           // sub-product width
    localparam int unsigned N   = 3 * H;           // carry-save width
    localparam int unsigned SW  = CMUL_SLICE_W;
    localparam int unsigned NS  = N / SW;           // adder slices

    // pp_flat slot k: a nibble k[1], b nibble k[0] (0=low, 1=high).
    logic [CMUL_NUM_PP*PPW-1:0] pp_flat;
    logic [N-1:0]  op0, op1, op2;
    logic [N-1:0]  csa_s, csa_c;
    logic [N-1:0]  add_y;
    logic [N-1:0]  add_sum;
    logic [NS-1:0] slc_gp, slc_gg;
    logic [NS:0]   slc_car;

    genvar k;
    generate
        for (k = 0; k < int'(CMUL_NUM_PP); k++) begin : g_pp
            localparam int unsigned ASEL = k / 2;
            localparam int unsigned BSEL = k % 2;
            nib_mult #(.H(H)) u_nib (
                .x (a[ASEL*H +: H]),
                .y (b[BSEL*H +: H]),
                .p (pp_flat[k*PPW +: PPW])
            );
        end
    endgenerate

    // Purpose: align the three operands that share product weight >= H.
    always_comb begin
        op0 = {pp_flat[3*PPW +: PPW], pp_flat[H +: H]};
        op1 = N'(pp_flat[1*PPW +: PPW]);
        op2 = N'(pp_flat[2*PPW +: PPW]);
    end

    csa_row #(.N(N)) u_csa (
        .in0 (op0),
        .in1 (op1),
        .in2 (op2),
        .s   (csa_s),
        .c   (csa_c)
    );

    // Purpose: second-level operand, each column's carry from the one below.
    always_comb begin
        add_y = {csa_c[N-2:0], 1'b0};
    end

    generate
        for (k = 0; k < int'(NS); k++) begin : g_slc
            add_slice #(.SW(SW)) u_slc (
                .x   (csa_s[k*SW +: SW]),
                .y   (add_y[k*SW +: SW]),
                .cin (slc_car[k]),
                .s   (add_sum[k*SW +: SW]),
                .gp  (slc_gp[k]),
                .gg  (slc_gg[k])
            );
        end
    endgenerate

    grp_lookahead #(.NS(NS)) u_cla (
        .gp  (slc_gp),
        .gg  (slc_gg),
        .car (slc_car)
    );

    // Purpose: assemble the product; the low bits bypass all adders.
    always_comb begin
        product = {add_sum, pp_flat[0 +: H]};
    end
endmodule

// File: rtl/composed_mul8_chk.sv
`timescale 1ns/1ps
// Module: composed_mul8_chk
// Assertion checker bound to composed_mul8. The design is combinational,
// so the checks are immediate assertions on settled values.
module composed_mul8_chk #(
    parameter int unsigned W  = 8,
    parameter int unsigned N  = 12,
    parameter int unsigned NS = 3
) (
    input logic [W-1:0]   a,
    input logic [W-1:0]   b,
    input logic [2*W-1:0] product,
    input logic [4*W-1:0] pp_flat,
    input logic [N-1:0]   op0,
    input logic [N-1:0]   op1,
    input logic [N-1:0]   op2,
    input logic [N-1:0]   csa_s,
    input logic [N-1:0]   csa_c,
    input logic [NS-1:0]  slc_gp,
    input logic [NS-1:0]  slc_gg,
    input logic [NS:0]    slc_car
);
    localparam int unsigned H = W / 2;

    // Purpose: end-to-end product and low-nibble bypass.
    always_comb begin
        assert_product_R1: assert (product == (2*W)'(a) * (2*W)'(b))
            else $error("R1 product %0h for %0h*%0h", product, a, b);
        assert_low_nibble_R3: assert (product[H-1:0] == pp_flat[H-1:0])
            else $error("R3 low nibble mismatch");
    end

    // Purpose: each sub-product matches its nibble pair.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            assert_subprod_R2: assert (pp_flat[k*W +: W] ==
                W'(a[(k/2)*H +: H]) * W'(b[(k%2)*H +: H]))
                else $error("R2 sub-product %0d wrong", k);
        end
    end

    // Purpose: carry-save identity and discarded carry bits.
    always_comb begin
        assert_csa_sum_R4: assert ((N+2)'(csa_s) + ((N+2)'(csa_c) << 1) ==
            (N+2)'(op0) + (N+2)'(op1) + (N+2)'(op2))
            else $error("R4 carry-save identity broken");
        assert_csa_top_R7: assert (csa_c[N-1] == 1'b0)
            else $error("R7 carry-save top carry set");
        assert_cout_R7: assert (slc_car[NS] == 1'b0)
            else $error("R7 final slice carry-out set");
    end

    // Purpose: lookahead carries obey the slice recurrence.
    always_comb begin
        assert_car0_R5: assert (slc_car[0] == 1'b0)
            else $error("R5 first slice carry-in not zero");
        for (int i = 0; i < int'(NS); i++) begin
            assert_lookahead_R5: assert (slc_car[i+1] ==
                (slc_gg[i] | (slc_gp[i] & slc_car[i])))
                else $error("R5 lookahead carry %0d wrong", i + 1);
        end
    end
endmodule

bind composed_mul8 composed_mul8_chk #(.W(W), .N(N), .NS(NS)) u_chk (
    .a       (a),
    .b       (b),
    .product (product),
    .pp_flat (pp_flat),
    .op0     (op0),
    .op1     (op1),
    .op2     (op2),
    .csa_s   (csa_s),
    .csa_c   (csa_c),
    .slc_gp  (slc_gp),
    .slc_gg  (slc_gg),
    .slc_car (slc_car)
);

// File: tb/tb_composed_mul8.sv
`timescale 1ns/1ps
// Bench for composed_mul8: exhaustive sweep, seeded random and directed
// corner cases, all against a behavioural multiply.
module tb_composed_mul8;
    localparam int unsigned W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   a = '0;
    logic [W-1:0]   b = '0;
    logic [2*W-1:0] product;
    int             checks = 0;
    int             errors = 0;
    bit             done = 1'b0;

    always #2.5 clk = ~clk;

    composed_mul8 #(.W(W)) dut (.a(a), .b(b), .product(product));

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        return (2*W)'(x) * (2*W)'(y);
    endfunction

    // Drive just after an edge, let the next edge pass, sample 1 ns later.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
        a = x;
        b = y;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%0h b=%0h actual=%0h expected=%0h", req, a, b, got, exp);
        end
    endtask

    task automatic run_pair(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
        apply(x, y);
        check(req, product, ref_mul(x, y));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] first;
        void'($urandom(32'h5EED_1234));
        // Reset phase: operands held at zero.
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset state", product, '0);
        rst_n = 1'b1;

        // R6: zero on either side.
        run_pair("R6", 8'h00, 8'hFF);
        run_pair("R6", 8'hA7, 8'h00);
        // R8: identity operand.
        run_pair("R8", 8'h01, 8'hC3);
        apply(8'h5A, 8'h01);
        check("R8", product, 16'h005A);
        // R7: largest operands.
        apply(8'hFF, 8'hFF);
        check("R7", product, 16'hFE01);
        // R2: isolate single sub-products.
        apply(8'h0F, 8'hF0); check("R2 low x high", product, 16'h0E10);
        apply(8'hF0, 8'h0F); check("R2 high x low", product, 16'h0E10);
        apply(8'hF0, 8'hF0); check("R2 high x high", product, 16'hE100);
        apply(8'h0D, 8'h0B); check("R2 low x low", product, 16'h008F);
        // R3: low nibble against low x low product.
        for (int i = 0; i < 64; i++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            apply(x, y);
            check("R3", {12'h000, product[3:0]}, {12'h000, 4'(x[3:0] * y[3:0])});
        end
        // R4/R5: long carry chains through the carry-save row and slices.
        for (int i = 0; i < 256; i++) begin
            run_pair("R4 R5 carry chain", 8'hFF, W'(i));
        end
        // R9: swapped operands give the same product.
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            apply(x, y);
            first = product;
            apply(y, x);
            check("R9", product, first);
        end
        // R1: seeded random pairs.
        for (int i = 0; i < 2000; i++) begin
            run_pair("R1 random", W'($urandom), W'($urandom));
        end
        // R1: full sweep of all operand pairs.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                run_pair("R1 sweep", W'(i), W'(j));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule